// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block decides when a small processor core may stop its clocks, and how deeply. It watches the strobes the core raises when it executes a wait-for-interrupt or wait-for-event instruction, and the strobe it raises when it returns from its last active exception handler to thread code. It combines these with three static control bits: deep sleep, sleep-on-exit and low-power regulator. From them it selects a light sleep, where only the core clock stops, or a stop mode, where every clock in the core domain stops and the PLL and both oscillators are switched off.

Stop entry is held off while the flash programming engine or the peripheral bus bridge reports that it is busy. The block records which instruction put the core to sleep. It then wakes only on an interrupt for a wait-for-interrupt entry and only on a wakeup event for a wait-for-event entry. On leaving stop it first restarts the internal oscillator and waits for it to report ready. The PLL and external oscillator stay off until software starts them again with a start pulse.

Top module: `lpm_entry_ctrl`

## Requirements
- R1: With deep sleep clear and sleep-on-exit clear, a wfi or wfe strobe in run moves the block to sleep at the next edge. In sleep only the core clock enable is low. Peripheral clocks, the internal oscillator and the PLL and external oscillator enables keep their run values.
- R2: With sleep-on-exit set and deep sleep clear, a wfi strobe alone leaves the block in run. An exception-return strobe moves it to sleep with interrupt wakeup.
- R3: Sleep entered by wfi ends only on irq_i, and sleep entered by wfe ends only on evt_i. If wfi and wfe strobe together with sleep-on-exit clear, the entry counts as wfi.
- R4: A wake condition present at an edge in sleep returns the block to run at that edge, so the core clock enable is high in the following cycle.
- R5: With deep sleep set, a wfi or wfe strobe in run moves the block to stop-pending. In stop-pending the core clock is gated and peripheral clocks stay on. In stop, every clock enable, the PLL enable and both oscillator enables are low.
- R6: The block leaves stop-pending for stop only at an edge where flash_busy_i and bus_busy_i are both low. While either is high it stays pending.
- R7: lpreg_i is sampled at the edge that enters stop. reg_lp_o is high only in stop and only if that sample was 1. Later changes of lpreg_i have no effect until the next entry.
- R8: A wake condition in stop-pending takes priority over stop entry and returns the block to run at that edge. The PLL and external oscillator enables are kept.
- R9: A wake condition in stop moves the block to an oscillator-wait state, in which the internal oscillator is enabled and all clocks stay gated. It enters run at the first edge with osc_rdy_i high. After stop, the PLL and external oscillator enables are low.
- R10: pll_start_i and hse_start_i pulses set the PLL and external oscillator enables in run, sleep and stop-pending. They are ignored in stop and in the oscillator-wait state.
- R11: mode_o reads 00 in run, 01 in sleep, 10 in stop-pending, and 11 in stop and in the oscillator-wait state. Reset puts the block in run with the PLL and external oscillator off.
- R12: An exception-return strobe with sleep-on-exit clear or deep sleep set has no effect. Entry strobes outside run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wfi_i | input | 1 | Wait-for-interrupt executed strobe |
| wfe_i | input | 1 | Wait-for-event executed strobe |
| exc_ret_i | input | 1 | Return to thread from last handler strobe |
| deep_i | input | 1 | Deep sleep selects stop |
| soe_i | input | 1 | Sleep-on-exit enable |
| lpreg_i | input | 1 | Regulator low-power choice for stop |
| flash_busy_i | input | 1 | Flash programming in progress |
| bus_busy_i | input | 1 | Peripheral bus access in progress |
| irq_i | input | 1 | Any enabled interrupt pending |
| evt_i | input | 1 | Wakeup event |
| osc_rdy_i | input | 1 | Internal oscillator ready |
| pll_start_i | input | 1 | Software PLL start pulse |
| hse_start_i | input | 1 | Software external oscillator start pulse |
| core_clk_en_o | output | 1 | Core clock gate enable |
| per_clk_en_o | output | 1 | Peripheral clock gate enable |
| pll_en_o | output | 1 | PLL enable |
| hsi_en_o | output | 1 | Internal oscillator enable |
| hse_en_o | output | 1 | External oscillator enable |
| reg_lp_o | output | 1 | Regulator low-power request |
| mode_o | output | 2 | Current mode code |

## Verification
Two functions can meet at one edge while the block is stop-pending: the busy flags dropping, which would complete stop entry, and a wake condition, which cancels it. The bench drops the last busy flag in the same cycle as it raises the recorded wake source. A reference model predicts run rather than stop for that edge, and also predicts that the PLL enable survives. A second collision makes wfi and wfe strobe together, and the check is that only irq_i, not evt_i, ends the resulting sleep.

// File: rtl/lpm_pkg.sv
// Package lpm_pkg
// Shared state type and mode codes for the low-power entry controller.
// Assumes a single controller clock domain.
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_SLEEP = 3'd1,
        ST_PEND  = 3'd2,
        ST_STOP  = 3'd3,
        ST_WAKE  = 3'd4
    } lpm_state_e;

    localparam int MODE_W = 2;
    localparam logic [MODE_W-1:0] MODE_RUN   = 2'b00;
    localparam logic [MODE_W-1:0] MODE_SLEEP = 2'b01;
    localparam logic [MODE_W-1:0] MODE_PEND  = 2'b10;
    localparam logic [MODE_W-1:0] MODE_STOP  = 2'b11;

endpackage

// File: rtl/lpm_entry_decode.sv
// Module lpm_entry_decode
// Combinational choice of target mode from the entry strobes and control bits.
// Assumes strobes are single-cycle pulses; only consulted while in run.
module lpm_entry_decode (
    input  logic wfi_i,
    input  logic wfe_i,
    input  logic exc_ret_i,
    input  logic deep_i,
    input  logic soe_i,
    output logic go_sleep_o,
    output logic go_pend_o,
    output logic kind_evt_o
);

    logic wfi_now;

    // Decide between sleep, stop request and no entry, and the wake source.
    always_comb begin
        wfi_now    = wfi_i && !soe_i;
        go_pend_o  = deep_i && (wfi_i || wfe_i);
        go_sleep_o = !deep_i && (wfi_now || wfe_i || (exc_ret_i && soe_i));
        if (deep_i)
            kind_evt_o = !wfi_i;
        else
            kind_evt_o = !wfi_now && wfe_i;
    end

endmodule

// File: rtl/lpm_mode_fsm.sv
// Module lpm_mode_fsm
// Mode sequencer: run, sleep, stop-pending, stop and oscillator wait.
// Records the wake source at entry and samples the regulator choice at stop entry.
// Assumes busy flags and wake inputs are synchronous to clk.
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_sleep_i,
    input  logic       go_pend_i,
    input  logic       kind_evt_i,
    input  logic       lpreg_i,
    input  logic       flash_busy_i,
    input  logic       bus_busy_i,
    input  logic       irq_i,
    input  logic       evt_i,
    input  logic       osc_rdy_i,
    output lpm_state_e state_o,
    output logic       lp_o
);

    lpm_state_e st_q, st_d;
    logic       evt_q, evt_d;
    logic       lp_q, lp_d;
    logic       wake;
    logic       idle;

    // Wake condition follows the source recorded at entry.
    always_comb begin
        wake = evt_q ? evt_i : irq_i;
        idle = !flash_busy_i && !bus_busy_i;
    end

    // Next-state and side register selection.
    always_comb begin
        st_d  = st_q;
        evt_d = evt_q;
        lp_d  = lp_q;
        case (st_q)
            ST_RUN: begin
                if (go_pend_i) begin
                    st_d  = ST_PEND;
                    evt_d = kind_evt_i;
                end else if (go_sleep_i) begin
                    st_d  = ST_SLEEP;
                    evt_d = kind_evt_i;
                end
            end
            ST_SLEEP: if (wake) st_d = ST_RUN;
            ST_PEND: begin
                if (wake) begin
                    st_d = ST_RUN;
                end else if (idle) begin
                    st_d = ST_STOP;
                    lp_d = lpreg_i;
                end
            end
            ST_STOP: if (wake) st_d = ST_WAKE;
            ST_WAKE: if (osc_rdy_i) st_d = ST_RUN;
            default: st_d = ST_RUN;
        endcase
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            evt_q <= 1'b0;
            lp_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            evt_q <= evt_d;
            lp_q  <= lp_d;
        end
    end

    assign state_o = st_q;
    assign lp_o    = lp_q;

    // R6: pending holds while a busy flag is up and no wake arrives.
    p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PEND && (flash_busy_i || bus_busy_i) && !(evt_q ? evt_i : irq_i))
        |=> st_q == ST_PEND);

    // R4: sleep ends at the edge where the recorded source is active.
    p_sleep_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SLEEP && (evt_q ? evt_i : irq_i)) |=> st_q == ST_RUN);

    // R9: clocks stay gated until the oscillator reports ready.
    p_osc_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAKE && !osc_rdy_i) |=> st_q == ST_WAKE);

    // R7: regulator choice is the value present at the stop-entry edge.
    p_lp_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PEND && idle && !(evt_q ? evt_i : irq_i))
        |=> (st_q == ST_STOP && lp_q == $past(lpreg_i)));

endmodule

// File: rtl/lpm_clk_ctrl.sv
// Module lpm_clk_ctrl
// Drives clock gates, oscillator and PLL enables and the regulator request
// from the current mode. Holds the software-started PLL and external
// oscillator enables, which are dropped by stop.
module lpm_clk_ctrl
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  lpm_state_e        state_i,
    input  logic              lp_i,
    input  logic              pll_start_i,
    input  logic              hse_start_i,
    output logic              core_clk_en_o,
    output logic              per_clk_en_o,
    output logic              pll_en_o,
    output logic              hsi_en_o,
    output logic              hse_en_o,
    output logic              reg_lp_o,
    output logic [MODE_W-1:0] mode_o
);

    logic awake;
    logic pll_q, hse_q;

    // Domain is clocked in run, sleep and stop-pending.
    assign awake = (state_i == ST_RUN) || (state_i == ST_SLEEP) || (state_i == ST_PEND);

    // Software start latches, cleared once stop is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pll_q <= 1'b0;
            hse_q <= 1'b0;
        end else if (!awake) begin
            pll_q <= 1'b0;
            hse_q <= 1'b0;
        end else begin
            if (pll_start_i) pll_q <= 1'b1;
            if (hse_start_i) hse_q <= 1'b1;
        end
    end

    // Output decode from mode.
    always_comb begin
        core_clk_en_o = (state_i == ST_RUN);
        per_clk_en_o  = awake;
        pll_en_o      = pll_q && awake;
        hse_en_o      = hse_q && awake;
        hsi_en_o      = (state_i != ST_STOP);
        reg_lp_o      = (state_i == ST_STOP) && lp_i;
        case (state_i)
            ST_RUN:   mode_o = MODE_RUN;
            ST_SLEEP: mode_o = MODE_SLEEP;
            ST_PEND:  mode_o = MODE_PEND;
            default:  mode_o = MODE_STOP;
        endcase
    end

    // R9: after stop, PLL and external oscillator remain off until restarted.
    p_pll_off_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_WAKE) |-> (!pll_q && !hse_q));

    // R10: start pulses ignored outside the awake modes.
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!awake && pll_start_i) |=> !pll_q);

endmodule

// File: rtl/lpm_entry_ctrl.sv
// Module lpm_entry_ctrl
// Top of the low-power mode entry controller: entry decode, mode sequencer
// and clock/oscillator control. Assumes all inputs synchronous to clk.
module lpm_entry_ctrl
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wfi_i,
    input  logic       wfe_i,
    input  logic       exc_ret_i,
    input  logic       deep_i,
    input  logic       soe_i,
    input  logic       lpreg_i,
    input  logic       flash_busy_i,
    input  logic       bus_busy_i,
    input  logic       irq_i,
    input  logic       evt_i,
    input  logic       osc_rdy_i,
    input  logic       pll_start_i,
    input  logic       hse_start_i,
    output logic       core_clk_en_o,
    output logic       per_clk_en_o,
    output logic       pll_en_o,
    output logic       hsi_en_o,
    output logic       hse_en_o,
    output logic       reg_lp_o,
    output logic [1:0] mode_o
);

    logic       go_sleep, go_pend, kind_evt, lp;
    lpm_state_e state;

    lpm_entry_decode u_decode (
        .wfi_i      (wfi_i),
        .wfe_i      (wfe_i),
        .exc_ret_i  (exc_ret_i),
        .deep_i     (deep_i),
        .soe_i      (soe_i),
        .go_sleep_o (go_sleep),
        .go_pend_o  (go_pend),
        .kind_evt_o (kind_evt)
    );

    lpm_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_sleep_i   (go_sleep),
        .go_pend_i    (go_pend),
        .kind_evt_i   (kind_evt),
        .lpreg_i      (lpreg_i),
        .flash_busy_i (flash_busy_i),
        .bus_busy_i   (bus_busy_i),
        .irq_i        (irq_i),
        .evt_i        (evt_i),
        .osc_rdy_i    (osc_rdy_i),
        .state_o      (state),
        .lp_o         (lp)
    );

    lpm_clk_ctrl u_clk (
        .clk           (clk),
        .rst_n         (rst_n),
        .state_i       (state),
        .lp_i          (lp),
        .pll_start_i   (pll_start_i),
        .hse_start_i   (hse_start_i),
        .core_clk_en_o (core_clk_en_o),
        .per_clk_en_o  (per_clk_en_o),
        .pll_en_o      (pll_en_o),
        .hsi_en_o      (hsi_en_o),
        .hse_en_o      (hse_en_o),
        .reg_lp_o      (reg_lp_o),
        .mode_o        (mode_o)
    );

    // R5: stop keeps every clock and source off.
    p_stop_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b11 && !hsi_en_o) |-> (!core_clk_en_o && !per_clk_en_o && !pll_en_o && !hse_en_o));

    // R7: regulator request only in stop.
    p_reg_lp_only_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_lp_o |-> (mode_o == 2'b11 && !hsi_en_o));

endmodule

// File: tb/lpm_entry_ctrl_bench.sv
// Bench for lpm_entry_ctrl: a behavioural reference model stepped at each
// rising edge and compared with every output at each falling edge.
module lpm_entry_ctrl_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wfi = 0, wfe = 0, exc_ret = 0, deep = 0, soe = 0, lpreg = 0;
    logic fbusy = 0, bbusy = 0, irq = 0, evt = 0, ordy = 0, pll_st = 0, hse_st = 0;
    logic core_en, per_en, pll_en, hsi_en, hse_en, reg_lp;
    logic [1:0] mode;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit started = 0;
    string cur_req = "R11";

    // model state: 0 run, 1 sleep, 2 pending, 3 stop, 4 osc wait
    int m_st = 0;
    bit m_evt = 0, m_lp = 0, m_pll = 0, m_hse = 0;

    always #10 clk = ~clk;

    lpm_entry_ctrl u_lpm_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .wfi_i(wfi), .wfe_i(wfe), .exc_ret_i(exc_ret),
        .deep_i(deep), .soe_i(soe), .lpreg_i(lpreg), .flash_busy_i(fbusy),
        .bus_busy_i(bbusy), .irq_i(irq), .evt_i(evt), .osc_rdy_i(ordy),
        .pll_start_i(pll_st), .hse_start_i(hse_st), .core_clk_en_o(core_en),
        .per_clk_en_o(per_en), .pll_en_o(pll_en), .hsi_en_o(hsi_en),
        .hse_en_o(hse_en), .reg_lp_o(reg_lp), .mode_o(mode)
    );

    // reference model step
    always @(posedge clk) begin
        bit wk;
        bit on;
        started = 1;
        if (!rst_n) begin
            m_st = 0; m_evt = 0; m_lp = 0; m_pll = 0; m_hse = 0;
        end else begin
            on = (m_st <= 2);
            if (on) begin
                if (pll_st) m_pll = 1;
                if (hse_st) m_hse = 1;
            end else begin
                m_pll = 0; m_hse = 0;
            end
            wk = m_evt ? evt : irq;
            if (m_st == 0) begin
                if (deep && (wfi || wfe)) begin
                    m_st = 2; m_evt = !wfi;
                end else if (!deep && wfi && !soe) begin
                    m_st = 1; m_evt = 0;
                end else if (!deep && wfe) begin
                    m_st = 1; m_evt = 1;
                end else if (!deep && soe && exc_ret) begin
                    m_st = 1; m_evt = 0;
                end
            end else if (m_st == 1) begin
                if (wk) m_st = 0;
            end else if (m_st == 2) begin
                if (wk) m_st = 0;
                else if (!fbusy && !bbusy) begin m_st = 3; m_lp = lpreg; end
            end else if (m_st == 3) begin
                if (wk) m_st = 4;
            end else begin
                if (ordy) m_st = 0;
            end
        end
    end

    // compare at falling edge
    always @(negedge clk) begin
        logic [8:0] got, exp;
        logic [1:0] em;
        if (started) begin
            em = (m_st == 0) ? 2'b00 : (m_st == 1) ? 2'b01 : (m_st == 2) ? 2'b10 : 2'b11;
            exp = {m_st == 0, m_st <= 2, m_pll && m_st <= 2, m_st != 3,
                   m_hse && m_st <= 2, m_st == 3 && m_lp, 1'b0, em};
            got = {core_en, per_en, pll_en, hsi_en, hse_en, reg_lp, 1'b0, mode};
            total++;
            if (got !== exp) begin
                bad++;
                $display("FAIL %s cycle %0d got=%b exp=%b", cur_req, cycles, got, exp);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_wfi(); wfi = 1; cyc(1); wfi = 0; endtask
    task automatic pulse_wfe(); wfe = 1; cyc(1); wfe = 0; endtask

    initial begin
        cur_req = "R11"; cyc(3); rst_n = 1; cyc(2);

        cur_req = "R10"; pll_st = 1; hse_st = 1; cyc(1); pll_st = 0; hse_st = 0; cyc(2);

        cur_req = "R1"; pulse_wfi(); cyc(3);
        cur_req = "R4"; irq = 1; cyc(1); irq = 0; cyc(2);

        cur_req = "R3"; pulse_wfe(); irq = 1; cyc(3); irq = 0; evt = 1; cyc(1); evt = 0; cyc(2);
        wfi = 1; wfe = 1; cyc(1); wfi = 0; wfe = 0; evt = 1; cyc(3); evt = 0; irq = 1; cyc(1); irq = 0; cyc(2);

        cur_req = "R2"; soe = 1; pulse_wfi(); cyc(2); exc_ret = 1; cyc(1); exc_ret = 0; cyc(2);
        irq = 1; cyc(1); irq = 0; cyc(1);

        cur_req = "R12"; soe = 0; exc_ret = 1; cyc(1); exc_ret = 0; cyc(2);
        deep = 1; soe = 1; exc_ret = 1; cyc(1); exc_ret = 0; cyc(2); soe = 0; deep = 0;
        pulse_wfe(); wfi = 1; cyc(2); wfi = 0; evt = 1; cyc(1); evt = 0; cyc(1);

        cur_req = "R6"; deep = 1; fbusy = 1; lpreg = 0; pulse_wfi(); cyc(4);
        bbusy = 1; fbusy = 0; cyc(3);
        cur_req = "R7"; lpreg = 1; bbusy = 0; cyc(1); lpreg = 0; cyc(3);
        cur_req = "R10"; pll_st = 1; cyc(1); pll_st = 0; cyc(1);
        cur_req = "R5"; evt = 1; cyc(2); evt = 0; cyc(1);
        cur_req = "R9"; irq = 1; cyc(1); irq = 0; cyc(4); ordy = 1; cyc(1); ordy = 0; cyc(2);

        cur_req = "R8"; pll_st = 1; hse_st = 1; cyc(1); pll_st = 0; hse_st = 0;
        bbusy = 1; pulse_wfe(); cyc(2); bbusy = 0; evt = 1; cyc(1); evt = 0; cyc(3);

        cur_req = "R5"; lpreg = 0; pulse_wfe(); cyc(2); irq = 1; cyc(2); irq = 0;
        evt = 1; cyc(1); evt = 0; cyc(2); ordy = 1; cyc(1); ordy = 0; deep = 0; cyc(2);

        cur_req = "R11"; rst_n = 0; cyc(2); rst_n = 1; cyc(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule